// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This controller sits on the host side of a command-driven flash device and erases a run of consecutive blocks. A single start pulse supplies the first block, the number of blocks and a mode bit. It then drives the device bus for each block. It writes the erase setup byte and the confirm byte, then polls the device status byte with separate read strobes until the ready bit comes up. The status byte is decoded in a fixed priority order.

In per-block mode the status is checked after every block, and the run stops at the first failure. In deferred mode the blocks are erased back to back, and the device's sticky error bits are checked once after the last block. If an error is found, a clear-status command is written. Every run that completes normally ends with a write of the array-read command. A run that never sees the ready bit stops with a timeout flag. The results stay on the outputs until the next run is accepted.

Top module: `erase_seq`

## Requirements
- R1: For each block the bus carries a write of 0x20 and then, on the next cycle, a write of 0xD0. Both go to address `block << OFF_W`. Blocks are visited in ascending order, starting at `first_blk_i`.
- R2: Each status poll is a one-cycle `fl_oe_o` pulse followed by at least one cycle with `fl_oe_o` low. Polling repeats until status bit 7 reads 1.
- R3: The status decode gives `err_code_o` = 1 when bit 3 is set, whatever the other bits are. Otherwise it gives 2 when bits 4 and 5 are both set, otherwise 3 when bit 5 is set, and otherwise 0. `ok_o` is 1 only when the code is 0.
- R4: When `check_each_i`=1, the status is decoded after every block. The first error ends the run, and `fail_blk_o` holds that block's number.
- R5: When `check_each_i`=0, the status is decoded only after the last block, and `fail_blk_o` then holds the number of the last block.
- R6: A run that ends with a nonzero error code writes 0x50 exactly once, on the cycle just before the final 0xFF write. A clean run never writes 0x50.
- R7: Every run without a timeout ends with exactly one write of 0xFF, after which `done_o` rises.
- R8: If `POLL_LIMIT` reads pass without bit 7 set, the run stops with `timeout_o`=1, `ok_o`=0 and `err_code_o`=0. No further write follows the last 0xD0.
- R9: A block count of 0 produces no erase writes, only the 0xFF write, and the run ends with `ok_o`=1.
- R10: A `start_i` pulse that arrives while a run is in progress is ignored. The number of blocks erased does not change.
- R11: After reset, `done_o`, `ok_o`, `timeout_o`, `fl_we_o` and `fl_oe_o` are all 0.
- R12: `fl_we_o` and `fl_oe_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| first_blk_i | input | BLK_W | First block to erase |
| blk_cnt_i | input | CNT_W | Number of blocks |
| check_each_i | input | 1 | 1: check per block, 0: check once at end |
| fl_addr_o | output | BLK_W+OFF_W | Device address |
| fl_wdata_o | output | 8 | Command byte |
| fl_we_o | output | 1 | Write strobe, one cycle per command |
| fl_oe_o | output | 1 | Read strobe, one cycle per poll |
| fl_rdata_i | input | 8 | Status byte, sampled at the end of the read strobe cycle |
| done_o | output | 1 | Run finished; held until next start |
| ok_o | output | 1 | Run finished without error or timeout |
| err_code_o | output | 2 | 0 ok, 1 supply fault, 2 sequence error, 3 erase failure |
| timeout_o | output | 1 | Ready never seen within the poll limit |
| fail_blk_o | output | BLK_W | Block where the error was detected |

## Verification
If the state register or the block walker goes wrong, the command stream shows it directly. An erase pair then lands at the wrong address, a confirm appears without its setup byte, or a block is skipped. The device model flags each of these at the write where it happens. A wrong decode or a wrong choice of path shows up at `done_o` as a wrong code or block number. A clear-status write that is missing or out of place, or a missing 0xFF write, is visible one cycle before `done_o` rises. A broken poll counter shows up as a timeout reported after the wrong number of reads.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  localparam logic [7:0] CMD_SETUP   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_VPP   = 2'd1,
    ERR_SEQ   = 2'd2,
    ERR_ERASE = 2'd3
  } err_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_CONF, S_POLL, S_GAP, S_CLR, S_ARR
  } state_e;
endpackage

// File: rtl/erase_status_decode.sv
module erase_status_decode
  import erase_seq_pkg::*;
(
  input  logic [2:0] err_bits_i,  // {bit5, bit4, bit3}
  output err_e       code_o
);
  always_comb begin
    if (err_bits_i[0])                        code_o = ERR_VPP;
    else if (err_bits_i[1] && err_bits_i[2])  code_o = ERR_SEQ;
    else if (err_bits_i[2])                   code_o = ERR_ERASE;
    else                                      code_o = ERR_NONE;
  end
endmodule

// File: rtl/erase_block_walker.sv
module erase_block_walker #(
  parameter int BLK_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [BLK_W-1:0] first_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [BLK_W-1:0] blk_o,
  output logic             last_o
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_o <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      blk_o <= first_i;
      rem_q <= cnt_i;
    end else if (step_i) begin
      blk_o <= blk_o + 1'b1;
      rem_q <= rem_q - 1'b1;
    end
  end

  assign last_o = (rem_q == CNT_W'(1));

  a_r1_step_not_past_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> rem_q > CNT_W'(1));
endmodule

// File: rtl/erase_poll_timer.sv
module erase_poll_timer #(
  parameter int POLL_LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic expired_o
);
  localparam int CW = $clog2(POLL_LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (inc_i && !expired_o)     cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= CW'(POLL_LIMIT));

  a_r8_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(POLL_LIMIT));
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int BLK_W      = 4,
  parameter int CNT_W      = 5,
  parameter int OFF_W      = 4,
  parameter int POLL_LIMIT = 1000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [BLK_W-1:0]       first_blk_i,
  input  logic [CNT_W-1:0]       blk_cnt_i,
  input  logic                   check_each_i,
  output logic [BLK_W+OFF_W-1:0] fl_addr_o,
  output logic [7:0]             fl_wdata_o,
  output logic                   fl_we_o,
  output logic                   fl_oe_o,
  input  logic [7:0]             fl_rdata_i,
  output logic                   done_o,
  output logic                   ok_o,
  output logic [1:0]             err_code_o,
  output logic                   timeout_o,
  output logic [BLK_W-1:0]       fail_blk_o
);
  localparam int ADDR_W = BLK_W + OFF_W;

  state_e           state_q;
  logic             each_q;
  logic             ready_q;
  logic [2:0]       err_bits_q;
  err_e             err_q;
  err_e             code;
  logic [BLK_W-1:0] cur_blk;
  logic             last_blk;
  logic             load, step, expired;

  erase_block_walker #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_walk (
    .clk_i, .rst_ni, .load_i(load), .step_i(step),
    .first_i(first_blk_i), .cnt_i(blk_cnt_i),
    .blk_o(cur_blk), .last_o(last_blk)
  );

  erase_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_tmr (
    .clk_i, .rst_ni, .clr_i(state_q == S_CONF), .inc_i(state_q == S_POLL),
    .expired_o(expired)
  );

  erase_status_decode u_dec (.err_bits_i(err_bits_q), .code_o(code));

  assign load = (state_q == S_IDLE) && start_i;
  // advance when ready and (deferred, or checked clean) and more blocks remain
  assign step = (state_q == S_GAP) && ready_q && !last_blk &&
                (!each_q || code == ERR_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      each_q     <= 1'b0;
      ready_q    <= 1'b0;
      err_bits_q <= '0;
      err_q      <= ERR_NONE;
      done_o     <= 1'b0;
      ok_o       <= 1'b0;
      timeout_o  <= 1'b0;
      fail_blk_o <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          each_q     <= check_each_i;
          err_q      <= ERR_NONE;
          done_o     <= 1'b0;
          ok_o       <= 1'b0;
          timeout_o  <= 1'b0;
          fail_blk_o <= '0;
          state_q    <= (blk_cnt_i == '0) ? S_ARR : S_SETUP;
        end
        S_SETUP: state_q <= S_CONF;
        S_CONF:  state_q <= S_POLL;
        S_POLL: begin
          ready_q    <= fl_rdata_i[7];
          err_bits_q <= fl_rdata_i[5:3];
          state_q    <= S_GAP;
        end
        S_GAP: begin
          if (!ready_q) begin
            if (expired) begin
              timeout_o <= 1'b1;
              done_o    <= 1'b1;
              state_q   <= S_IDLE;
            end else begin
              state_q <= S_POLL;
            end
          end else if (each_q || last_blk) begin
            if (code != ERR_NONE) begin
              err_q      <= code;
              fail_blk_o <= cur_blk;
              state_q    <= S_CLR;
            end else if (last_blk) begin
              state_q <= S_ARR;
            end else begin
              state_q <= S_SETUP;
            end
          end else begin
            state_q <= S_SETUP;
          end
        end
        S_CLR: state_q <= S_ARR;
        S_ARR: begin
          ok_o    <= (err_q == ERR_NONE);
          done_o  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_we_o    = 1'b0;
    fl_wdata_o = CMD_ARRAY;
    unique case (state_q)
      S_SETUP: begin fl_we_o = 1'b1; fl_wdata_o = CMD_SETUP;   end
      S_CONF:  begin fl_we_o = 1'b1; fl_wdata_o = CMD_CONFIRM; end
      S_CLR:   begin fl_we_o = 1'b1; fl_wdata_o = CMD_CLEAR;   end
      S_ARR:   begin fl_we_o = 1'b1; fl_wdata_o = CMD_ARRAY;   end
      default: ;
    endcase
  end

  assign fl_oe_o    = (state_q == S_POLL);
  assign fl_addr_o  = (state_q == S_SETUP || state_q == S_CONF) ?
                      {cur_blk, {OFF_W{1'b0}}} : ADDR_W'(0);
  assign err_code_o = err_q;

  a_r12_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_o && fl_oe_o));
  a_r2_read_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_oe_o |=> !fl_oe_o);
  a_r1_confirm_follows_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_we_o && fl_wdata_o == CMD_CONFIRM) |->
      ($past(fl_we_o && fl_wdata_o == CMD_SETUP) && $past(fl_addr_o) == fl_addr_o));
  a_r6_clear_before_array: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_we_o && fl_wdata_o == CMD_ARRAY && err_q != ERR_NONE) |->
      $past(fl_we_o && fl_wdata_o == CMD_CLEAR));
  a_r8_timeout_not_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!ok_o && err_code_o == 2'd0));
  a_r3_ok_zero_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> (err_code_o == 2'd0 && done_o));
endmodule

// File: tb/sim_erase_seq.sv
module sim_erase_seq;
  localparam int BLK_W = 4, CNT_W = 5, OFF_W = 4, LIM = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic start = 1'b0, each = 1'b0;
  logic [BLK_W-1:0] first = '0;
  logic [CNT_W-1:0] cnt = '0;
  logic [7:0] addr, wdata, rd_q;
  logic we, oe, done, ok, tmo;
  logic [1:0] code;
  logic [BLK_W-1:0] fblk;

  erase_seq #(.BLK_W(BLK_W), .CNT_W(CNT_W), .OFF_W(OFF_W), .POLL_LIMIT(LIM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .first_blk_i(first),
    .blk_cnt_i(cnt), .check_each_i(each), .fl_addr_o(addr), .fl_wdata_o(wdata),
    .fl_we_o(we), .fl_oe_o(oe), .fl_rdata_i(rd_q), .done_o(done), .ok_o(ok),
    .err_code_o(code), .timeout_o(tmo), .fail_blk_o(fblk));

  // device model, updated at negedge
  int busy_left, cfg_busy, n_setup, n_clr, n_ff, n_rd, addr_err, overlap;
  logic [3:0] inj_blk;
  logic [7:0] inj, sr_err, setup_addr, first_addr, last_wd, prev_wd;
  logic prev_we;

  always @(negedge clk) begin
    if (we && oe) overlap++;
    if (we) begin
      prev_wd = last_wd;
      last_wd = wdata;
      case (wdata)
        8'h20: begin
          if (n_setup == 0) first_addr = addr;
          n_setup++; setup_addr = addr;
        end
        8'hD0: begin
          if (addr != setup_addr) addr_err++;
          busy_left = cfg_busy;
          if (addr[7:4] == inj_blk) sr_err = sr_err | inj;
        end
        8'h50: begin sr_err = 8'h00; n_clr++; end
        8'hFF: n_ff++;
        default: addr_err++;
      endcase
    end
    if (oe) begin
      n_rd++;
      rd_q = (busy_left == 0 ? 8'h80 : 8'h00) | sr_err;
      if (busy_left > 0) busy_left--;
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_dev(input int busy, input logic [3:0] ib, input logic [7:0] iv);
    cfg_busy = busy; inj_blk = ib; inj = iv; sr_err = 0; busy_left = 0;
    n_setup = 0; n_clr = 0; n_ff = 0; n_rd = 0; addr_err = 0; overlap = 0;
    last_wd = 0; prev_wd = 0; rd_q = 0; first_addr = 0;
  endtask

  int wd_hit = 0;
  task automatic run_wait(input logic [3:0] f, input logic [4:0] c, input logic e);
    @(negedge clk);
    first = f; cnt = c; each = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    if (!done) begin wd_hit++; chk("watchdog", 0, 1); end
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [3:0] first; logic [3:0] cnt; logic each; logic [7:0] busy;
    logic [3:0] ib; logic [7:0] iv; logic [1:0] code; logic [3:0] fail;
    logic [3:0] nset;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{4'd2,  4'd3, 1'b1, 8'd2, 4'd0, 8'h00, 2'd0, 4'd0, 4'd3}, // R1 R4 clean
    '{4'd0,  4'd4, 1'b1, 8'd1, 4'd1, 8'h20, 2'd3, 4'd1, 4'd2}, // R4 stop at blk 1
    '{4'd3,  4'd2, 1'b1, 8'd3, 4'd3, 8'h30, 2'd2, 4'd3, 4'd1}, // R3 seq
    '{4'd5,  4'd3, 1'b0, 8'd2, 4'd5, 8'h20, 2'd3, 4'd7, 4'd3}, // R5 deferred
    '{4'd0,  4'd1, 1'b1, 8'd1, 4'd0, 8'h28, 2'd1, 4'd0, 4'd1}, // R3 vpp wins
    '{4'd8,  4'd2, 1'b0, 8'd4, 4'd8, 8'h38, 2'd1, 4'd9, 4'd2}, // R3 R5
    '{4'd4,  4'd0, 1'b1, 8'd1, 4'd0, 8'h00, 2'd0, 4'd0, 4'd0}, // R9 empty
    '{4'd15, 4'd1, 1'b0, 8'd0, 4'd0, 8'h00, 2'd0, 4'd0, 4'd1}  // R2 ready at once
  };

  initial begin
    clr_dev(0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R11 done", int'(done), 0);
    chk("R11 ok", int'(ok), 0);
    chk("R11 tmo", int'(tmo), 0);
    chk("R11 we", int'(we), 0);
    chk("R11 oe", int'(oe), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      clr_dev(int'(VEC[v].busy), VEC[v].ib, VEC[v].iv);
      run_wait(VEC[v].first, {1'b0, VEC[v].cnt}, VEC[v].each);
      chk("R3 code", int'(code), int'(VEC[v].code));
      chk("R3 ok", int'(ok), int'(VEC[v].code == 2'd0));
      chk("R4 R5 fail blk", int'(fblk), int'(VEC[v].fail));
      chk("R1 R4 setups", n_setup, int'(VEC[v].nset));
      chk("R1 addr pairing", addr_err, 0);
      if (VEC[v].nset != 0) chk("R1 first addr", int'(first_addr), int'({VEC[v].first, 4'h0}));
      chk("R6 clears", n_clr, int'(VEC[v].code != 2'd0));
      if (VEC[v].code != 2'd0) chk("R6 clear before array", int'(prev_wd), 8'h50);
      chk("R7 array writes", n_ff, 1);
      chk("R7 last write", int'(last_wd), 8'hFF);
      chk("R12 overlap", overlap, 0);
      chk("R8 no timeout", int'(tmo), 0);
    end

    // R2: polls per block = busy + 1 reads
    clr_dev(5, 0, 0);
    run_wait(4'd1, 5'd2, 1'b1);
    chk("R2 read count", n_rd, 12);
    chk("R2 ok", int'(ok), 1);

    // R8 timeout
    clr_dev(200, 0, 0);
    run_wait(4'd6, 5'd3, 1'b1);
    chk("R8 timeout", int'(tmo), 1);
    chk("R8 ok", int'(ok), 0);
    chk("R8 code", int'(code), 0);
    chk("R8 reads", n_rd, LIM);
    chk("R8 no array write", n_ff, 0);
    chk("R8 last write", int'(last_wd), 8'hD0);

    // R10 start ignored while busy
    clr_dev(6, 0, 0);
    @(negedge clk);
    first = 4'd0; cnt = 5'd2; each = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    first = 4'd9; cnt = 5'd5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    @(negedge clk);
    chk("R10 setups", n_setup, 2);
    chk("R10 first addr", int'(first_addr), 0);
    chk("R10 ok", int'(ok), 1);

    // R11 reset mid-run
    clr_dev(50, 0, 0);
    run_wait(4'd0, 5'd0, 1'b0);
    @(negedge clk); first = 4'd2; cnt = 5'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 done after reset", int'(done), 0);
    chk("R11 we after reset", int'(we), 0);
    chk("R11 oe after reset", int'(oe), 0);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog run expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule